// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block produces the three clocks that one audio serial port needs: an oversampled clock, a word (frame) clock and a bit clock. All three come from one fast master clock, nominally 32 to 48 MHz. A phase accumulator adds a programmable frequency word on every master-clock cycle. Each carry out of the accumulator is one edge of the oversampled clock. As a result, every generated edge falls on a master-clock edge, and any rate a fraction of the master clock allows can be produced. The price is a period that can vary by one master-clock cycle.

The word clock spans 256 or 512 oversampled periods, selected by one control bit. The bit clock divides each word evenly into 64 or 32 bit periods, depending on the serial format. Master operation is enabled in two steps. A master bit first turns the word-clock and bit-clock pins into outputs. A separate generate bit then starts them toggling. Until generation starts, the pins hold an idle level that depends on the format. The SPI-style format is slave-only, so master mode is refused for it. One instance serves one audio path, and two instances can run at unrelated rates. The block has no streaming data interface, so no valid/ready handshake or back-pressure applies. All pins are plain control and clock levels.

Top module: `aclk_gen`

## Requirements
- R1: While rst_n is low, ock_o, wclk_o and bclk_o are all 0.
- R2: With ock_en high and freq_word F held constant, the number of clk cycles D between successive rising edges of ock_o satisfies |D*F - 2^(ACC_W+1)| < F. That is, the period is within one clk cycle of the ideal 2^(ACC_W+1)/F.
- R3: When ock_en is low, ock_o is 0 from the next clk cycle on.
- R4: A word lasts 2*R accumulator carries, where R is 512 when ratio_hi=1 and 256 when ratio_hi=0. Over two words, the measured clk count C between wclk_o edges satisfies |C*F - 4*R*2^ACC_W| < F.
- R5: Each word holds B bit-clock periods, where B is 64 for fmt 0 and 1 and 32 for fmt 2. This gives 2*B bclk_o edges per word, and every wclk_o edge falls in the same clk cycle as a bclk_o edge.
- R6: wclk_oe and bclk_oe are both 1 exactly when master_en=1 and fmt is not 3, the SPI-style slave-only code.
- R7: While not generating, wclk_o and bclk_o hold the idle levels of the format. fmt 0 gives (wclk,bclk)=(1,1), fmt 1 gives (0,1), and fmt 2 and fmt 3 give (0,0).
- R8: Generation runs only when master_en, gen_en and a non-SPI fmt are all present. With fmt 3, gen_en has no effect: both pins stay at 0 and the output enables stay 0.
- R9: When generation starts, the counters restart. Exactly B bclk_o edges occur up to and including the first wclk_o edge, which falls half a word after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 to 48 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | ACC_W | Phase increment added to the accumulator each cycle |
| ratio_hi | input | 1 | 1: 512 oversampled periods per word; 0: 256 |
| fmt | input | 2 | Serial format: 0 I2S, 1 left-justified, 2 PCM short frame, 3 SPI-style (slave only) |
| ock_en | input | 1 | Enables the oversampled clock output |
| master_en | input | 1 | Makes the word and bit clock pins outputs |
| gen_en | input | 1 | Starts word and bit clock generation (needs master_en) |
| ock_o | output | 1 | Oversampled clock |
| wclk_o | output | 1 | Word clock |
| bclk_o | output | 1 | Bit clock |
| wclk_oe | output | 1 | Output enable for the word clock pin |
| bclk_oe | output | 1 | Output enable for the bit clock pin |

## Verification
The assertions run on every cycle and cover the local rules. Carry spacing stays within one cycle of ideal for any constant frequency word. The oversampled clock is silent when disabled. Word and bit clock edges occur only after a carry, and word edges coincide with bit edges. The pins sit quiet under the slave-only format. Only the bench's sweeps over format, ratio and frequency word can show the long-run properties. These are the average word rate against the programmed word, the exact bit count per word, the clean start of the first half word, and the idle levels and pin directions held before generation.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LEFT = 2'd1,
    FMT_PCM  = 2'd2,
    FMT_SPI  = 2'd3
  } fmt_e;

  // idle level of the word clock pin before generation
  function automatic logic idle_word(fmt_e f);
    return (f == FMT_I2S);
  endfunction

  // idle level of the bit clock pin before generation
  function automatic logic idle_bit(fmt_e f);
    return (f == FMT_I2S) || (f == FMT_LEFT);
  endfunction

  // wide frames carry the larger bit count per word
  function automatic logic wide_frame(fmt_e f);
    return (f != FMT_PCM);
  endfunction
endpackage

// File: rtl/aclk_phase_acc.sv
module aclk_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ock_en,
  input  logic [ACC_W-1:0] freq_word,
  output logic             tick_o,
  output logic             ock_o
);
  localparam int PW = 2*ACC_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             carry;
  logic             tick_q, ock_q;

  assign sum   = {1'b0, acc_q} + {1'b0, freq_word};
  assign carry = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
      ock_q  <= 1'b0;
    end else begin
      acc_q  <= run ? sum[ACC_W-1:0] : '0;
      tick_q <= carry;
      if (!ock_en)    ock_q <= 1'b0;
      else if (carry) ock_q <= ~ock_q;
    end
  end

  assign tick_o = tick_q;
  assign ock_o  = ock_q;

  // carry spacing monitor for the fractional-division bound
  logic [ACC_W:0]   gap_q;
  logic             valid_q;
  logic [ACC_W-1:0] fw_q;
  logic [PW-1:0]    prod_hi, prod_lo, full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q   <= '0;
      valid_q <= 1'b0;
      fw_q    <= '0;
    end else begin
      fw_q <= freq_word;
      if (!run) begin
        gap_q   <= 1;
        valid_q <= 1'b0;
      end else if (carry) begin
        gap_q   <= 1;
        valid_q <= (freq_word == fw_q);
      end else begin
        if (gap_q != '1) gap_q <= gap_q + 1'b1;
        if (freq_word != fw_q) valid_q <= 1'b0;
      end
    end
  end

  assign prod_hi = PW'(gap_q) * PW'(freq_word);
  assign prod_lo = PW'(gap_q - 1'b1) * PW'(freq_word);
  assign full    = PW'(1) << ACC_W;

  assert_carry_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && valid_q && freq_word == fw_q) |-> (prod_hi + PW'(freq_word) > full) && (prod_lo < full));

  assert_ock_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ock_en |=> !ock_o);
endmodule

// File: rtl/aclk_frame_cnt.sv
module aclk_frame_cnt #(
  parameter int RATIO_LO_LOG2   = 8,
  parameter int RATIO_HI_LOG2   = 9,
  parameter int BPW_WIDE_LOG2   = 6,
  parameter int BPW_NARROW_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic ratio_hi,
  input  logic wide,
  input  logic idle_w,
  input  logic idle_b,
  output logic wclk_o,
  output logic bclk_o
);
  localparam int CW = RATIO_HI_LOG2 + 1;
  localparam int PW = $clog2(CW + 1);

  logic [CW-1:0] cnt_q, cnt_nxt, last;
  logic [PW-1:0] wpos, bpos;
  logic          w_q, b_q;

  assign wpos = ratio_hi ? PW'(RATIO_HI_LOG2) : PW'(RATIO_LO_LOG2);
  assign bpos = wpos - (wide ? PW'(BPW_WIDE_LOG2) : PW'(BPW_NARROW_LOG2));
  assign last = ratio_hi ? {CW{1'b1}} : CW'((32'd1 << (RATIO_LO_LOG2 + 1)) - 32'd1);
  assign cnt_nxt = (cnt_q >= last) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      w_q   <= 1'b0;
      b_q   <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      w_q   <= idle_w;
      b_q   <= idle_b;
    end else if (tick) begin
      cnt_q <= cnt_nxt;
      w_q   <= idle_w ^ cnt_nxt[wpos];
      b_q   <= idle_b ^ cnt_nxt[bpos];
    end
  end

  assign wclk_o = w_q;
  assign bclk_o = b_q;

  // monitor state: active and configuration one cycle back
  logic       act_q;
  logic [3:0] cfg_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      act_q <= active;
      cfg_q <= {ratio_hi, wide, idle_w, idle_b};
    end
  end

  assert_word_on_bit_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && active && cfg_q == {ratio_hi, wide, idle_w, idle_b} && wclk_o != $past(wclk_o))
      |-> (bclk_o != $past(bclk_o)));

  assert_edge_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && active && cfg_q == {ratio_hi, wide, idle_w, idle_b} && bclk_o != $past(bclk_o))
      |-> $past(tick));
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int ACC_W           = 16,
  parameter int RATIO_LO_LOG2   = 8,
  parameter int RATIO_HI_LOG2   = 9,
  parameter int BPW_WIDE_LOG2   = 6,
  parameter int BPW_NARROW_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  input  logic             ratio_hi,
  input  logic [1:0]       fmt,
  input  logic             ock_en,
  input  logic             master_en,
  input  logic             gen_en,
  output logic             ock_o,
  output logic             wclk_o,
  output logic             bclk_o,
  output logic             wclk_oe,
  output logic             bclk_oe
);
  fmt_e fmt_s;
  logic drive, gen_active, run, tick;

  assign fmt_s      = fmt_e'(fmt);
  assign drive      = master_en && (fmt_s != FMT_SPI);
  assign gen_active = drive && gen_en;
  assign run        = ock_en || gen_active;
  assign wclk_oe    = drive;
  assign bclk_oe    = drive;

  aclk_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ock_en    (ock_en),
    .freq_word (freq_word),
    .tick_o    (tick),
    .ock_o     (ock_o)
  );

  aclk_frame_cnt #(
    .RATIO_LO_LOG2   (RATIO_LO_LOG2),
    .RATIO_HI_LOG2   (RATIO_HI_LOG2),
    .BPW_WIDE_LOG2   (BPW_WIDE_LOG2),
    .BPW_NARROW_LOG2 (BPW_NARROW_LOG2)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (gen_active),
    .tick     (tick),
    .ratio_hi (ratio_hi),
    .wide     (wide_frame(fmt_s)),
    .idle_w   (idle_word(fmt_s)),
    .idle_b   (idle_bit(fmt_s)),
    .wclk_o   (wclk_o),
    .bclk_o   (bclk_o)
  );

  // slave-only format held for two cycles: pins must be quiet at 0
  logic [1:0] spi_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                spi_run_q <= '0;
    else if (fmt_s != FMT_SPI) spi_run_q <= '0;
    else if (spi_run_q != 2'd2) spi_run_q <= spi_run_q + 1'b1;
  end

  assert_spi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_run_q == 2'd2) |-> (!wclk_o && !bclk_o));
endmodule

// File: tb/tb_aclk_gen.sv
module tb_aclk_gen;
  localparam int CLK_PERIOD = 24;
  localparam int ACC_W      = 16;
  localparam int WATCHDOG   = 190000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [ACC_W-1:0] freq_word = '0;
  logic             ratio_hi = 1'b0;
  logic [1:0]       fmt = 2'd0;
  logic             ock_en = 1'b0, master_en = 1'b0, gen_en = 1'b0;
  logic             ock_o, wclk_o, bclk_o, wclk_oe, bclk_oe;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aclk_gen #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .ratio_hi(ratio_hi),
    .fmt(fmt), .ock_en(ock_en), .master_en(master_en), .gen_en(gen_en),
    .ock_o(ock_o), .wclk_o(wclk_o), .bclk_o(bclk_o),
    .wclk_oe(wclk_oe), .bclk_oe(bclk_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bits_per_word(input int f);
    return (f < 2) ? 64 : 32;
  endfunction
  function automatic int exp_idle_w(input int f);
    return (f == 0) ? 1 : 0;
  endfunction
  function automatic int exp_idle_b(input int f);
    return (f < 2) ? 1 : 0;
  endfunction

  task automatic run_gen(input int f, input int rh, input int fw);
    int     b   = bits_per_word(f);
    longint r   = rh ? 512 : 256;
    int     wc  = 0, bc = 0, b1 = 0, misalign = 0;
    longint t1  = 0, t5 = 0, meas, err;
    logic   pw, pb;
    fmt = 2'(f); ratio_hi = rh[0]; freq_word = ACC_W'(fw);
    master_en = 1'b1; gen_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(wclk_o == exp_idle_w(f)[0], "R7", "idle wclk", wclk_o, exp_idle_w(f));
    chk(bclk_o == exp_idle_b(f)[0], "R7", "idle bclk", bclk_o, exp_idle_b(f));
    chk(wclk_oe && bclk_oe, "R6", "oe with master", {wclk_oe, bclk_oe}, 3);
    pw = wclk_o; pb = bclk_o;
    gen_en = 1'b1;
    for (int i = 0; i < 40000 && wc < 5; i++) begin
      @(negedge clk);
      if (bclk_o != pb) bc++;
      if (wclk_o != pw) begin
        wc++;
        if (bclk_o == pb) misalign++;
        if (wc == 1) begin
          chk(bc == b, "R9", "bit edges up to first word edge", bc, b);
          b1 = bc; t1 = cyc;
        end
        if (wc == 5) t5 = cyc;
      end
      pw = wclk_o; pb = bclk_o;
    end
    chk(wc == 5, "R4", "word edges seen", wc, 5);
    chk(bc - b1 == 4*b, "R5", "bit edges over two words", bc - b1, 4*b);
    chk(misalign == 0, "R5", "word edge without bit edge", misalign, 0);
    meas = t5 - t1;
    err  = meas*fw - 4*r*(64'd1 << ACC_W);
    chk(err < fw && err > -fw, "R4", "two-word clk count",
        meas, (4*r*(64'd1 << ACC_W))/fw);
    gen_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(wclk_o == exp_idle_w(f)[0] && bclk_o == exp_idle_b(f)[0], "R7",
        "idle after stop", {wclk_o, bclk_o}, {exp_idle_w(f)[0], exp_idle_b(f)[0]});
    master_en = 1'b0;
    @(negedge clk);
    chk(!wclk_oe && !bclk_oe, "R6", "oe without master", {wclk_oe, bclk_oe}, 0);
  endtask

  task automatic run_ock(input int fw);
    longint last = -1, d;
    int     edges = 0, bad = 0;
    logic   p;
    freq_word = ACC_W'(fw); ock_en = 1'b1;
    @(negedge clk); p = ock_o;
    for (int i = 0; i < 20000 && edges < 8; i++) begin
      @(negedge clk);
      if (ock_o && !p) begin
        if (last >= 0) begin
          d = (cyc - last)*fw - (64'd2 << ACC_W);
          if (!(d < fw && d > -fw)) bad++;
        end
        last = cyc; edges++;
      end
      p = ock_o;
    end
    chk(edges == 8, "R2", "ock rising edges", edges, 8);
    chk(bad == 0, "R2", "ock periods out of bound", bad, 0);
    ock_en = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      if (ock_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R3", "ock high while disabled", bad, 0);
  endtask

  task automatic run_spi();
    int bad = 0;
    fmt = 2'd3; ratio_hi = 1'b0; freq_word = 16'hffff;
    master_en = 1'b1; gen_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      if (wclk_o || bclk_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8", "pins moved in slave-only format", bad, 0);
    chk(!wclk_oe && !bclk_oe, "R6", "oe in slave-only format", {wclk_oe, bclk_oe}, 0);
    master_en = 1'b0; gen_en = 1'b0;
  endtask

  initial begin
    fmt = 2'd0; master_en = 1'b1; gen_en = 1'b1; ock_en = 1'b1; freq_word = 16'hffff;
    repeat (6) @(negedge clk);
    chk(!ock_o && !wclk_o && !bclk_o, "R1", "outputs in reset",
        {ock_o, wclk_o, bclk_o}, 0);
    master_en = 1'b0; gen_en = 1'b0; ock_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_ock(65535);
    run_ock(30001);
    run_ock(777);
    for (int f = 0; f < 3; f++)
      for (int rh = 0; rh < 2; rh++) begin
        run_gen(f, rh, 65535);
        run_gen(f, rh, 30001);
      end
    run_spi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule